// File: doc/BRIEF.md
# Write-Absorbing Saver Buffer for a Sleeping Memory Module

This block is a small fully associative line store that sits between the L2 cache controller and one memory module that spends most of its time in a low-power state. The L2 side is the only client. It sends two kinds of request: a line read and a dirty write-back. Write-backs land in the buffer and do not reach the module. Reads that find their line in the buffer are answered locally. In both cases the module is left asleep.

The module is woken only when the buffer cannot serve a request. This happens on a read miss, or on a write-back that finds every slot taken and no matching address. While the module is awake, every held line is written back to it, one line per memory handshake, in ascending slot order. After that the whole buffer is invalidated. A read miss then fetches the requested line from memory and returns it to L2. A write that overflowed the buffer is placed into the emptied buffer. The L2 port is stalled for the whole sequence.

Top module: `wsb_top`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid`, `mem_wake` and `mem_valid` are 0, and the buffer holds no line, so the first read misses and produces no write-back.
- R2: A read whose address is held is answered in the cycle after acceptance with `resp_valid`=1, `resp_hit`=1 and the held data, and `mem_wake` stays 0.
- R3: A write-back accepted while a slot is free is stored without any memory traffic: `mem_wake` stays 0 and `req_ready` stays 1.
- R4: A write-back to an address already held replaces that line's data and takes no new slot, so it never causes a flush, and a later read returns the newest data.
- R5: A read miss raises `mem_wake` and writes back every held line (`mem_write`=1), one per handshake, in ascending slot order. Slots are filled lowest-free-first. The miss then issues one memory read (`mem_write`=0) of the requested address and answers with `resp_hit`=0 and the memory data.
- R6: After a read miss the buffer is empty, so a following read of any previously held address misses and returns the data that was written back.
- R7: A write-back that arrives with every slot taken and no address match wakes the module, writes all lines back in slot order, empties the buffer, and then holds the new line, so a following read of it hits.
- R8: `mem_valid` is only raised while `mem_wake` is 1, and `req_ready` is 0 whenever `mem_wake` is 1.
- R9: Once raised, `mem_valid` together with `mem_addr`, `mem_write` and `mem_wdata` holds steady until the cycle in which `mem_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | L2 request present |
| req_write | input | 1 | 1 = dirty write-back, 0 = line read |
| req_addr | input | AW | Line address |
| req_wdata | input | DW | Write-back line data |
| req_ready | output | 1 | Request accepted this cycle when 1 with req_valid |
| resp_valid | output | 1 | One-cycle read answer strobe |
| resp_hit | output | 1 | Answer came from the buffer (1) or from memory (0) |
| resp_rdata | output | DW | Read answer data |
| mem_wake | output | 1 | Module must be active |
| mem_valid | output | 1 | Memory transfer request |
| mem_write | output | 1 | 1 = write-back line, 0 = line read |
| mem_addr | output | AW | Memory line address |
| mem_wdata | output | DW | Write-back data |
| mem_ready | input | 1 | Memory completes the transfer this cycle |
| mem_rdata | input | DW | Memory read data, valid with mem_ready on a read |

## Verification
The bench builds the block with four slots, six-bit line addresses and 32-bit lines, so the whole memory behind it fits in a 64-entry bench array. Random traffic drawn from a pool of twelve addresses against only four slots makes hits, same-address overwrites, overflow flushes and read-miss drains frequent. The memory side answers after random delays, which exercises the request hold and the one-line-per-handshake drain.

// File: rtl/wsb_pkg.sv
package wsb_pkg;

  // Controller phases: serving L2, draining lines to memory, fetching a missed line
  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_DRAIN = 2'd1,
    WS_FETCH = 2'd2
  } wsb_state_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/wsb_match.sv
module wsb_match #(
  parameter int LINES = 8,
  parameter int AW    = 26,
  parameter int IW    = 3
) (
  input  logic [LINES-1:0]         slot_valid,
  input  logic [LINES-1:0][AW-1:0] slot_tag,
  input  logic [AW-1:0]            key,
  output logic                     any_hit,
  output logic [IW-1:0]            hit_idx,
  output logic                     has_free,
  output logic [IW-1:0]            free_idx
);

  logic [LINES-1:0] match;

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match[g] = slot_valid[g] && (slot_tag[g] == key);
  end

  // Lowest index wins for both encoders
  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (match[i])       hit_idx  = IW'(i);
      if (!slot_valid[i]) free_idx = IW'(i);
    end
  end

  assign any_hit  = |match;
  assign has_free = ~&slot_valid;

endmodule

// File: rtl/wsb_store.sv
module wsb_store #(
  parameter int LINES = 8,
  parameter int AW    = 26,
  parameter int DW    = 64,
  parameter int IW    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IW-1:0]            wr_idx,
  input  logic [AW-1:0]            wr_tag,
  input  logic [DW-1:0]            wr_data,
  input  logic                     clr_all,
  output logic [LINES-1:0]         slot_valid,
  output logic [LINES-1:0]         slot_dirty,
  output logic [LINES-1:0][AW-1:0] slot_tag,
  output logic [LINES-1:0][DW-1:0] slot_data
);

  for (genvar g = 0; g < LINES; g++) begin : g_slot
    logic          v_q, d_q;
    logic [AW-1:0] t_q;
    logic [DW-1:0] x_q;
    logic          sel;

    assign sel = wr_en && (wr_idx == IW'(g));

    // A write to this slot wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (sel) begin
        v_q <= 1'b1;
        d_q <= 1'b1;
      end else if (clr_all) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        t_q <= wr_tag;
        x_q <= wr_data;
      end
    end

    assign slot_valid[g] = v_q;
    assign slot_dirty[g] = d_q;
    assign slot_tag[g]   = t_q;
    assign slot_data[g]  = x_q;
  end

endmodule

// File: rtl/wsb_ctrl.sv
module wsb_ctrl
  import wsb_pkg::*;
#(
  parameter int LINES = 8,
  parameter int AW    = 26,
  parameter int DW    = 64,
  parameter int IW    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [AW-1:0]            req_addr,
  input  logic [DW-1:0]            req_wdata,
  output logic                     req_ready,
  output logic                     resp_valid,
  output logic                     resp_hit,
  output logic [DW-1:0]            resp_rdata,
  input  logic                     any_hit,
  input  logic [IW-1:0]            hit_idx,
  input  logic                     has_free,
  input  logic [IW-1:0]            free_idx,
  input  logic [LINES-1:0]         slot_valid,
  input  logic [LINES-1:0]         slot_dirty,
  input  logic [LINES-1:0][AW-1:0] slot_tag,
  input  logic [LINES-1:0][DW-1:0] slot_data,
  output logic                     st_wr_en,
  output logic [IW-1:0]            st_wr_idx,
  output logic [AW-1:0]            st_wr_tag,
  output logic [DW-1:0]            st_wr_data,
  output logic                     st_clr,
  output logic                     mem_wake,
  output logic                     mem_valid,
  output logic                     mem_write,
  output logic [AW-1:0]            mem_addr,
  output logic [DW-1:0]            mem_wdata,
  input  logic                     mem_ready,
  input  logic [DW-1:0]            mem_rdata
);

  localparam logic [IW-1:0] LAST = IW'(LINES - 1);

  wsb_state_e    st_q, st_d;
  logic [IW-1:0] ptr_q, ptr_d;
  logic          pw_q, pw_d;
  logic [AW-1:0] pa_q;
  logic [DW-1:0] pd_q;
  logic          cap_en;
  logic          rv_d, rh_q, rh_d;
  logic          rv_q;
  logic [DW-1:0] rdat_q, rdat_d;
  logic          rdat_en;
  logic          wb_need;

  always_comb begin
    st_d       = st_q;
    ptr_d      = ptr_q;
    pw_d       = pw_q;
    cap_en     = 1'b0;
    rv_d       = 1'b0;
    rh_d       = rh_q;
    rdat_d     = rdat_q;
    rdat_en    = 1'b0;
    req_ready  = 1'b0;
    wb_need    = 1'b0;
    mem_valid  = 1'b0;
    mem_write  = 1'b0;
    mem_addr   = pa_q;
    mem_wdata  = '0;
    st_wr_en   = 1'b0;
    st_wr_idx  = hit_idx;
    st_wr_tag  = req_addr;
    st_wr_data = req_wdata;
    st_clr     = 1'b0;

    unique case (st_q)
      WS_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          if (req_write) begin
            if (any_hit) begin
              st_wr_en = 1'b1;
            end else if (has_free) begin
              st_wr_en  = 1'b1;
              st_wr_idx = free_idx;
            end else begin
              pw_d   = 1'b1;
              cap_en = 1'b1;
              ptr_d  = '0;
              st_d   = WS_DRAIN;
            end
          end else if (any_hit) begin
            rv_d    = 1'b1;
            rh_d    = 1'b1;
            rdat_d  = slot_data[hit_idx];
            rdat_en = 1'b1;
          end else begin
            pw_d   = 1'b0;
            cap_en = 1'b1;
            ptr_d  = '0;
            st_d   = WS_DRAIN;
          end
        end
      end
      WS_DRAIN: begin
        wb_need   = slot_valid[ptr_q] && slot_dirty[ptr_q];
        mem_valid = wb_need;
        mem_write = 1'b1;
        mem_addr  = slot_tag[ptr_q];
        mem_wdata = slot_data[ptr_q];
        if (!wb_need || mem_ready) begin
          if (ptr_q == LAST) begin
            st_clr = 1'b1;
            if (pw_q) begin
              st_wr_en   = 1'b1;
              st_wr_idx  = '0;
              st_wr_tag  = pa_q;
              st_wr_data = pd_q;
              st_d       = WS_IDLE;
            end else begin
              st_d = WS_FETCH;
            end
          end else begin
            ptr_d = ptr_q + 1'b1;
          end
        end
      end
      WS_FETCH: begin
        mem_valid = 1'b1;
        if (mem_ready) begin
          rv_d    = 1'b1;
          rh_d    = 1'b0;
          rdat_d  = mem_rdata;
          rdat_en = 1'b1;
          st_d    = WS_IDLE;
        end
      end
      default: st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WS_IDLE;
      ptr_q <= '0;
      pw_q  <= 1'b0;
      rv_q  <= 1'b0;
      rh_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
      pw_q  <= pw_d;
      rv_q  <= rv_d;
      rh_q  <= rh_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      pa_q <= req_addr;
      pd_q <= req_wdata;
    end
    if (rdat_en) rdat_q <= rdat_d;
  end

  assign resp_valid = rv_q;
  assign resp_hit   = rh_q;
  assign resp_rdata = rdat_q;
  assign mem_wake   = (st_q != WS_IDLE);

endmodule

// File: rtl/wsb_top.sv
module wsb_top
  import wsb_pkg::*;
#(
  parameter int LINES = 8,
  parameter int AW    = 26,
  parameter int DW    = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          resp_valid,
  output logic          resp_hit,
  output logic [DW-1:0] resp_rdata,
  output logic          mem_wake,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata
);

  localparam int IW = idx_bits(LINES);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic [LINES-1:0]         slot_valid, slot_dirty;
  logic [LINES-1:0][AW-1:0] slot_tag;
  logic [LINES-1:0][DW-1:0] slot_data;
  logic                     lookup_hit, has_free;
  logic [IW-1:0]            hit_idx, free_idx;
  logic                     st_wr_en, st_clr;
  logic [IW-1:0]            st_wr_idx;
  logic [AW-1:0]            st_wr_tag;
  logic [DW-1:0]            st_wr_data;

  wsb_match #(.LINES(LINES), .AW(AW), .IW(IW)) u_match (
    .slot_valid (slot_valid),
    .slot_tag   (slot_tag),
    .key        (req_addr),
    .any_hit    (lookup_hit),
    .hit_idx    (hit_idx),
    .has_free   (has_free),
    .free_idx   (free_idx)
  );

  wsb_store #(.LINES(LINES), .AW(AW), .DW(DW), .IW(IW)) u_store (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en      (st_wr_en),
    .wr_idx     (st_wr_idx),
    .wr_tag     (st_wr_tag),
    .wr_data    (st_wr_data),
    .clr_all    (st_clr),
    .slot_valid (slot_valid),
    .slot_dirty (slot_dirty),
    .slot_tag   (slot_tag),
    .slot_data  (slot_data)
  );

  wsb_ctrl #(.LINES(LINES), .AW(AW), .DW(DW), .IW(IW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .resp_rdata (resp_rdata),
    .any_hit    (lookup_hit),
    .hit_idx    (hit_idx),
    .has_free   (has_free),
    .free_idx   (free_idx),
    .slot_valid (slot_valid),
    .slot_dirty (slot_dirty),
    .slot_tag   (slot_tag),
    .slot_data  (slot_data),
    .st_wr_en   (st_wr_en),
    .st_wr_idx  (st_wr_idx),
    .st_wr_tag  (st_wr_tag),
    .st_wr_data (st_wr_data),
    .st_clr     (st_clr),
    .mem_wake   (mem_wake),
    .mem_valid  (mem_valid),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata)
  );

endmodule

// File: rtl/wsb_checker.sv
module wsb_checker #(
  parameter int AW = 26,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_int_n,
  input logic          req_valid,
  input logic          req_write,
  input logic          req_ready,
  input logic          lookup_hit,
  input logic          resp_valid,
  input logic          resp_hit,
  input logic          mem_wake,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_write,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata
);

  a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid && req_ready && !req_write && lookup_hit |=> resp_valid && resp_hit);

  a_r2_hit_stays_asleep: assert property (@(posedge clk) disable iff (!rst_int_n)
    resp_valid && resp_hit |-> !mem_wake);

  a_r3_absorb_no_wake: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid && req_ready && req_write && lookup_hit |=> !mem_wake && req_ready);

  a_r5_miss_from_fetch: assert property (@(posedge clk) disable iff (!rst_int_n)
    resp_valid && !resp_hit |-> $past(mem_valid && mem_ready && !mem_write));

  a_r8_traffic_needs_wake: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_valid |-> mem_wake);

  a_r8_stall_while_awake: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_wake |-> !req_ready);

  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write)
                                && $stable(mem_wdata));

endmodule

bind wsb_top wsb_checker #(.AW(AW), .DW(DW)) u_wsb_chk (
  .clk        (clk),
  .rst_int_n  (rst_int_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_ready  (req_ready),
  .lookup_hit (lookup_hit),
  .resp_valid (resp_valid),
  .resp_hit   (resp_hit),
  .mem_wake   (mem_wake),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_write  (mem_write),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata)
);

// File: tb/tb_wsb_top.sv
`timescale 1ns/1ps
module tb_wsb_top;

  localparam int LINES = 4;
  localparam int AW    = 6;
  localparam int DW    = 32;
  localparam int MEMN  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ready, resp_valid, resp_hit;
  logic [DW-1:0] resp_rdata;
  logic          mem_wake, mem_valid, mem_write, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  wsb_top #(.LINES(LINES), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
    .mem_wake(mem_wake), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  // Memory behind the buffer, and the bench's expected copy of it
  logic [DW-1:0] mem     [MEMN];
  logic [DW-1:0] exp_mem [MEMN];
  assign mem_rdata = mem[mem_addr];

  // Write-back log
  int            wb_n;
  logic [AW-1:0] wb_a [16];
  logic [DW-1:0] wb_d [16];

  // Reference buffer contents
  bit            m_v [LINES];
  logic [AW-1:0] m_t [LINES];
  logic [DW-1:0] m_d [LINES];

  int n_chk, n_fail;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Memory responder: random delay, one transfer per handshake
  initial begin : mem_side
    logic [AW-1:0] lat_a;
    logic [DW-1:0] lat_d;
    logic          lat_w;
    mem_ready = 1'b0;
    lat_a = '0; lat_d = '0; lat_w = 1'b0;
    forever begin
      @(negedge clk);
      if (mem_ready && lat_w) begin
        mem[lat_a] = lat_d;
        if (wb_n < 16) begin
          wb_a[wb_n] = lat_a;
          wb_d[wb_n] = lat_d;
        end
        wb_n++;
      end
      if (mem_valid && ($urandom % 4 != 0)) begin
        mem_ready = 1'b1;
        lat_a = mem_addr; lat_w = mem_write; lat_d = mem_wdata;
      end else begin
        mem_ready = 1'b0;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  function automatic int ref_find(input logic [AW-1:0] a);
    for (int i = 0; i < LINES; i++) if (m_v[i] && m_t[i] == a) return i;
    return -1;
  endfunction

  function automatic int ref_free();
    for (int i = 0; i < LINES; i++) if (!m_v[i]) return i;
    return -1;
  endfunction

  task automatic wait_idle();
    int t = 0;
    while (!req_ready && t < 500) begin
      @(negedge clk);
      t++;
    end
  endtask

  // Compare the logged write-backs with the reference slots, in slot order
  task automatic check_drain(input string req);
    int e = 0;
    for (int i = 0; i < LINES; i++) begin
      if (m_v[i]) begin
        check(wb_a[e] == m_t[i], req, "drain address order", 64'(wb_a[e]), 64'(m_t[i]));
        check(wb_d[e] == m_d[i], req, "drain data", 64'(wb_d[e]), 64'(m_d[i]));
        exp_mem[m_t[i]] = m_d[i];
        e++;
      end
    end
    check(wb_n == e, req, "drain line count", 64'(wb_n), 64'(e));
    for (int i = 0; i < LINES; i++) m_v[i] = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    int idx = ref_find(a);
    int t = 0;
    wait_idle();
    wb_n = 0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (idx >= 0) begin
      check(resp_valid && resp_hit, "R2", "hit strobe", 64'({resp_valid, resp_hit}), 64'(3));
      check(resp_rdata == m_d[idx], "R2", "hit data", 64'(resp_rdata), 64'(m_d[idx]));
      check(!mem_wake && wb_n == 0, "R2", "module woken on hit", 64'(mem_wake), 64'(0));
    end else begin
      check(mem_wake && !req_ready, "R8", "wake and stall on miss",
            64'({mem_wake, req_ready}), 64'(2));
      while (!resp_valid && t < 500) begin
        @(negedge clk);
        t++;
      end
      #1;
      check(resp_valid && !resp_hit, "R5", "miss answer strobe",
            64'({resp_valid, resp_hit}), 64'(2));
      check_drain("R5");
      check(resp_rdata == exp_mem[a], "R6", "miss data from memory",
            64'(resp_rdata), 64'(exp_mem[a]));
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int idx = ref_find(a);
    int fr  = ref_free();
    wait_idle();
    wb_n = 0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (idx >= 0 || fr >= 0) begin
      check(!mem_wake && req_ready, (idx >= 0) ? "R4" : "R3", "absorbed without wake",
            64'({mem_wake, req_ready}), 64'(1));
      if (idx >= 0) m_d[idx] = d;
      else begin m_v[fr] = 1'b1; m_t[fr] = a; m_d[fr] = d; end
    end else begin
      check(mem_wake, "R7", "overflow wakes module", 64'(mem_wake), 64'(1));
      wait_idle();
      #1;
      check_drain("R7");
      m_v[0] = 1'b1; m_t[0] = a; m_d[0] = d;
    end
  endtask

  initial begin : main
    n_chk = 0; n_fail = 0; wb_n = 0;
    void'($urandom(32'd1234));
    for (int i = 0; i < MEMN; i++) begin
      mem[i]     = 32'hA5A5_0000 ^ (32'(i) * 32'h0101_0101);
      exp_mem[i] = mem[i];
    end
    for (int i = 0; i < LINES; i++) m_v[i] = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check(req_ready && !resp_valid && !mem_wake && !mem_valid, "R1", "reset outputs",
          64'({req_ready, resp_valid, mem_wake, mem_valid}), 64'(8));
    do_read(6'd5);   // empty buffer: miss with no write-back (R1)

    // Fill, overwrite, hit
    do_write(6'd10, 32'h1000_000A);
    do_write(6'd11, 32'h1000_000B);
    do_write(6'd12, 32'h1000_000C);
    do_write(6'd11, 32'h2000_000B);  // R4 same slot
    do_write(6'd13, 32'h1000_000D);
    do_write(6'd10, 32'h2000_000A);  // R4 on a full buffer, no flush
    do_read(6'd11);                  // R2 newest data
    do_read(6'd13);

    // R7: overflow flush, then the new line is held
    do_write(6'd14, 32'h1000_000E);
    do_read(6'd14);
    do_read(6'd10);                  // R6: misses, returns drained data

    // R5: miss with several held lines, then R6 follow-up miss
    do_write(6'd20, 32'h3000_0014);
    do_write(6'd21, 32'h3000_0015);
    do_write(6'd22, 32'h3000_0016);
    do_read(6'd30);
    do_read(6'd21);

    // Random traffic on a small address pool
    for (int k = 0; k < 300; k++) begin
      logic [AW-1:0] a = AW'($urandom % 12);
      if ($urandom % 2 == 0) do_write(a, $urandom);
      else                   do_read(a);
    end

    wait_idle();
    for (int i = 0; i < MEMN; i++) begin
      // Memory matches expected for every line drained so far
      if (mem[i] != exp_mem[i])
        check(1'b0, "R5", "memory image", 64'(mem[i]), 64'(exp_mem[i]));
    end
    check(1'b1, "R5", "memory image scan", 64'(0), 64'(0));

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule